// File: doc/BRIEF.md
# Variable-Length Instruction Boundary Decoder

This block walks a byte stream of a small 32-bit variable-length instruction set and marks where each instruction begins and ends. Bytes arrive one per cycle over a valid/ready channel. The parser decides byte by byte which field comes next, because the presence and size of each later field depend on bits of earlier bytes. When the last byte of an instruction is taken, one registered record describes that instruction. The record gives its start address, its total length, its opcode and the optional fields it carried. For a short relative branch it also gives the resolved target.

Seven opcodes are understood: 3B and F7, which take an addressing byte; C7, which takes an addressing byte and then an immediate; BB, which takes only an immediate; C3, which stands alone; and 73 and EB, which take one signed offset byte. A leading 66h byte narrows the operand size, so a 4-byte immediate becomes 2 bytes. Any other opcode closes the instruction at once with an error flag, and the next byte starts a new instruction.

Back-pressure rules: a byte moves when `in_valid` and `in_ready` are both high on a rising clock edge. `in_ready` is low only while `base_load` is high. The record channel has no stall input, so each record is shown for exactly one cycle. A producer may hold `in_valid` high with the same byte for as long as it likes. A byte offered during a load is not taken.

Top module: `vlen_boundary_dec`

## Requirements
- R1: `in_ready` is low in exactly the cycles where `base_load` is high. A load sets the start address of the next instruction to `base_addr` and discards any instruction that is partly parsed.
- R2: After reset `out_valid` is low. `out_valid` is high for one cycle, in the cycle after the final byte of an instruction is accepted. Every instruction yields exactly one record.
- R3: C3 has length 1 (plus 1 with prefix). BB has length 5. 73 and EB have length 2. `out_len` is the total count of bytes, prefix included.
- R4: 3B and F7 are followed by an addressing byte whose bits [7:6] are the mode and bits [2:0] are the r/m field. The displacement length `out_disp_len` follows from the mode: mode 3 gives 0, mode 1 gives 1, mode 2 gives 4, and mode 0 gives 0 except when r/m=5, which gives 4. Bits [5:3] have no effect on the length.
- R5: A scale-index byte follows the addressing byte when mode≠3 and r/m=4. Any displacement comes after that scale-index byte.
- R6: C7 carries an addressing byte, an optional scale-index byte and an optional displacement, followed by a 4-byte immediate (`out_imm_len`=4).
- R7: 66h is a prefix only as the first byte of an instruction. It sets `out_has_pfx` and adds 1 to the length. It cuts the immediate of BB and C7 from 4 to 2 bytes and does not change any other field.
- R8: Each instruction's `out_start` equals the previous `out_start` plus the previous `out_len`, counted from the last loaded base.
- R9: For 73 and EB, `out_branch` is 1 and `out_target` = `out_start` + `out_len` + the offset byte sign-extended to 32 bits, modulo 2^32. For all other records `out_target` is 0.
- R10: Any opcode outside the supported set is flagged as an error. This includes a second 66h. The record has `out_err`=1, its length covers the bytes up to and including that opcode, and the next byte begins a new instruction.
- R11: `out_opcode` reports the opcode byte, and `out_has_amode` / `out_has_sidx` report whether an addressing byte and a scale-index byte were present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| base_load | input | 1 | Load `base_addr` as the next start address and flush the parser |
| base_addr | input | AW | Start address to load |
| in_valid | input | 1 | Stream byte offered |
| in_ready | output | 1 | Stream byte can be taken |
| in_byte | input | 8 | Stream byte |
| out_valid | output | 1 | One-cycle record strobe |
| out_start | output | AW | Start address of the instruction |
| out_len | output | LW | Total length in bytes |
| out_opcode | output | 8 | Opcode byte |
| out_has_pfx | output | 1 | Operand-size prefix present |
| out_has_amode | output | 1 | Addressing byte present |
| out_has_sidx | output | 1 | Scale-index byte present |
| out_disp_len | output | 3 | Displacement bytes (0, 1 or 4) |
| out_imm_len | output | 3 | Immediate bytes (0, 2 or 4) |
| out_branch | output | 1 | Short relative branch |
| out_target | output | AW | Resolved branch target |
| out_err | output | 1 | Unsupported opcode |

## Verification
A directed run follows a realistic loop of instructions and then isolates each addressing-byte shape. Mode 0 with r/m=5 is compared against a plain mode 0, and r/m=4 is compared against other r/m values, so the special displacement and scale-index rules are told apart from the plain mode table. Prefixed and unprefixed BB and C7 separate the narrowed immediate from the full one. A double prefix, a stray opcode and a load in the middle of an instruction show that error closing and flushing really restart the parse. Seeded random streams with idle gaps mix every opcode, prefix and addressing byte, and they check the start-address chain and the branch targets across the sign boundary of the offset byte.

// File: rtl/vld_pkg.sv
package vld_pkg;
  localparam logic [7:0] OP_PFX16  = 8'h66;
  localparam logic [7:0] OP_CMP_RM = 8'h3B;
  localparam logic [7:0] OP_MOV_RI = 8'hBB;
  localparam logic [7:0] OP_RET    = 8'hC3;
  localparam logic [7:0] OP_MOV_MI = 8'hC7;
  localparam logic [7:0] OP_GRP_RM = 8'hF7;
  localparam logic [7:0] OP_JCC8   = 8'h73;
  localparam logic [7:0] OP_JMP8   = 8'hEB;

  localparam logic [2:0] IMM_FULL   = 3'd4;
  localparam logic [2:0] IMM_NARROW = 3'd2;
  localparam logic [2:0] DISP_BYTE  = 3'd1;
  localparam logic [2:0] DISP_WORD  = 3'd4;

  typedef enum logic [2:0] {
    ST_HEAD,
    ST_OPC,
    ST_AMODE,
    ST_SIDX,
    ST_DISP,
    ST_IMM,
    ST_REL
  } vld_state_e;

  typedef struct packed {
    logic       known;
    logic       amode;
    logic       rel8;
    logic [2:0] imm_len;
  } vld_opinfo_t;
endpackage

// File: rtl/vld_opclass.sv
module vld_opclass
  import vld_pkg::*;
(
  input  logic [7:0]  opc,
  input  logic        narrow,
  output vld_opinfo_t info
);
  logic [2:0] imm_sz;
  assign imm_sz = narrow ? IMM_NARROW : IMM_FULL;

  always_comb begin
    info = '0;
    case (opc)
      OP_CMP_RM, OP_GRP_RM: begin
        info.known = 1'b1;
        info.amode = 1'b1;
      end
      OP_MOV_RI: begin
        info.known   = 1'b1;
        info.imm_len = imm_sz;
      end
      OP_MOV_MI: begin
        info.known   = 1'b1;
        info.amode   = 1'b1;
        info.imm_len = imm_sz;
      end
      OP_RET: info.known = 1'b1;
      OP_JCC8, OP_JMP8: begin
        info.known = 1'b1;
        info.rel8  = 1'b1;
      end
      default: info = '0;
    endcase
  end
endmodule

// File: rtl/vld_amode_dec.sv
module vld_amode_dec
  import vld_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [2:0] rm,
  output logic       need_sidx,
  output logic [2:0] disp_len
);
  localparam logic [1:0] MODE_REG  = 2'd3;
  localparam logic [2:0] RM_SIDX   = 3'd4;
  localparam logic [2:0] RM_ABS    = 3'd5;

  assign need_sidx = (mode != MODE_REG) && (rm == RM_SIDX);

  always_comb begin
    case (mode)
      2'd0:    disp_len = (rm == RM_ABS) ? DISP_WORD : 3'd0;
      2'd1:    disp_len = DISP_BYTE;
      2'd2:    disp_len = DISP_WORD;
      default: disp_len = 3'd0;
    endcase
  end
endmodule

// File: rtl/vld_branch.sv
module vld_branch #(
  parameter int AW = 32,
  parameter int LW = 4
) (
  input  logic [AW-1:0] start,
  input  logic [LW-1:0] len,
  input  logic [7:0]    rel,
  output logic [AW-1:0] target
);
  localparam int EXT = AW - 8;
  localparam int PAD = AW - LW;

  logic [AW-1:0] next_addr;
  logic [AW-1:0] rel_sx;

  assign next_addr = start + {{PAD{1'b0}}, len};
  assign rel_sx    = {{EXT{rel[7]}}, rel};
  assign target    = next_addr + rel_sx;
endmodule

// File: rtl/vld_seq.sv
module vld_seq
  import vld_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          take,
  input  logic [7:0]    in_byte,
  output logic          done,
  output logic [LW-1:0] rec_len,
  output logic [7:0]    rec_opc,
  output logic          rec_pfx,
  output logic          rec_amode,
  output logic          rec_sidx,
  output logic [2:0]    rec_dl,
  output logic [2:0]    rec_il,
  output logic          rec_br,
  output logic          rec_err
);
  vld_state_e    st_q, st_d;
  logic [LW-1:0] len_q, len_d;
  logic [7:0]    opc_q, opc_d;
  logic          pfx_q, pfx_d;
  logic          am_q, am_d;
  logic          sx_q, sx_d;
  logic [2:0]    dl_q, dl_d;
  logic [2:0]    il_q, il_d;
  logic [2:0]    cnt_q, cnt_d;

  vld_opinfo_t   info;
  logic          need_sidx;
  logic [2:0]    disp_len;

  vld_opclass u_opclass (
    .opc    (in_byte),
    .narrow (pfx_q),
    .info   (info)
  );

  vld_amode_dec u_amode (
    .mode      (in_byte[7:6]),
    .rm        (in_byte[2:0]),
    .need_sidx (need_sidx),
    .disp_len  (disp_len)
  );

  always_comb begin
    st_d    = st_q;
    len_d   = len_q;
    opc_d   = opc_q;
    pfx_d   = pfx_q;
    am_d    = am_q;
    sx_d    = sx_q;
    dl_d    = dl_q;
    il_d    = il_q;
    cnt_d   = cnt_q;
    done    = 1'b0;
    rec_br  = 1'b0;
    rec_err = 1'b0;
    if (take) begin
      len_d = len_q + 1'b1;
      case (st_q)
        ST_HEAD, ST_OPC: begin
          if (st_q == ST_HEAD && in_byte == OP_PFX16) begin
            pfx_d = 1'b1;
            st_d  = ST_OPC;
          end else begin
            opc_d = in_byte;
            am_d  = info.amode;
            il_d  = info.imm_len;
            if (!info.known) begin
              done    = 1'b1;
              rec_err = 1'b1;
            end else if (info.rel8) begin
              st_d = ST_REL;
            end else if (info.amode) begin
              st_d = ST_AMODE;
            end else if (info.imm_len != 3'd0) begin
              st_d  = ST_IMM;
              cnt_d = info.imm_len;
            end else begin
              done = 1'b1;
            end
          end
        end
        ST_AMODE: begin
          sx_d = need_sidx;
          dl_d = disp_len;
          if (need_sidx) begin
            st_d = ST_SIDX;
          end else if (disp_len != 3'd0) begin
            st_d  = ST_DISP;
            cnt_d = disp_len;
          end else if (il_q != 3'd0) begin
            st_d  = ST_IMM;
            cnt_d = il_q;
          end else begin
            done = 1'b1;
          end
        end
        ST_SIDX: begin
          if (dl_q != 3'd0) begin
            st_d  = ST_DISP;
            cnt_d = dl_q;
          end else if (il_q != 3'd0) begin
            st_d  = ST_IMM;
            cnt_d = il_q;
          end else begin
            done = 1'b1;
          end
        end
        ST_DISP: begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == 3'd1) begin
            if (il_q != 3'd0) begin
              st_d  = ST_IMM;
              cnt_d = il_q;
            end else begin
              done = 1'b1;
            end
          end
        end
        ST_IMM: begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == 3'd1) done = 1'b1;
        end
        ST_REL: begin
          rec_br = 1'b1;
          done   = 1'b1;
        end
        default: st_d = ST_HEAD;
      endcase
    end
  end

  assign rec_len   = len_d;
  assign rec_opc   = opc_d;
  assign rec_pfx   = pfx_d;
  assign rec_amode = am_d;
  assign rec_sidx  = sx_d;
  assign rec_dl    = dl_d;
  assign rec_il    = il_d;

  always_ff @(posedge clk) begin
    if (!rst_n || flush || (take && done)) begin
      st_q  <= ST_HEAD;
      len_q <= '0;
      opc_q <= '0;
      pfx_q <= 1'b0;
      am_q  <= 1'b0;
      sx_q  <= 1'b0;
      dl_q  <= '0;
      il_q  <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      len_q <= len_d;
      opc_q <= opc_d;
      pfx_q <= pfx_d;
      am_q  <= am_d;
      sx_q  <= sx_d;
      dl_q  <= dl_d;
      il_q  <= il_d;
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DISP || st_q == ST_IMM) |-> (cnt_q != 3'd0)); // R4

  AST_PFX_ONLY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPC) |-> pfx_q); // R7
endmodule

// File: rtl/vlen_boundary_dec.sv
module vlen_boundary_dec
  import vld_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_load,
  input  logic [AW-1:0] base_addr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_byte,
  output logic          out_valid,
  output logic [AW-1:0] out_start,
  output logic [LW-1:0] out_len,
  output logic [7:0]    out_opcode,
  output logic          out_has_pfx,
  output logic          out_has_amode,
  output logic          out_has_sidx,
  output logic [2:0]    out_disp_len,
  output logic [2:0]    out_imm_len,
  output logic          out_branch,
  output logic [AW-1:0] out_target,
  output logic          out_err
);
  localparam int PAD     = AW - LW;
  localparam int LEN_MAX = 11;

  logic          take;
  logic          done;
  logic          fire;
  logic [LW-1:0] rec_len;
  logic [7:0]    rec_opc;
  logic          rec_pfx, rec_amode, rec_sidx, rec_br, rec_err;
  logic [2:0]    rec_dl, rec_il;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] tgt;

  assign in_ready = ~base_load;
  assign take     = in_valid & in_ready;
  assign fire     = take & done;

  vld_seq #(.LW(LW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (base_load),
    .take      (take),
    .in_byte   (in_byte),
    .done      (done),
    .rec_len   (rec_len),
    .rec_opc   (rec_opc),
    .rec_pfx   (rec_pfx),
    .rec_amode (rec_amode),
    .rec_sidx  (rec_sidx),
    .rec_dl    (rec_dl),
    .rec_il    (rec_il),
    .rec_br    (rec_br),
    .rec_err   (rec_err)
  );

  vld_branch #(.AW(AW), .LW(LW)) u_branch (
    .start  (pc_q),
    .len    (rec_len),
    .rel    (in_byte),
    .target (tgt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q          <= '0;
      out_valid     <= 1'b0;
      out_start     <= '0;
      out_len       <= '0;
      out_opcode    <= '0;
      out_has_pfx   <= 1'b0;
      out_has_amode <= 1'b0;
      out_has_sidx  <= 1'b0;
      out_disp_len  <= '0;
      out_imm_len   <= '0;
      out_branch    <= 1'b0;
      out_target    <= '0;
      out_err       <= 1'b0;
    end else begin
      out_valid <= fire;
      if (base_load) begin
        pc_q <= base_addr;
      end else if (fire) begin
        pc_q <= pc_q + {{PAD{1'b0}}, rec_len};
      end
      if (fire) begin
        out_start     <= pc_q;
        out_len       <= rec_len;
        out_opcode    <= rec_opc;
        out_has_pfx   <= rec_pfx;
        out_has_amode <= rec_amode;
        out_has_sidx  <= rec_sidx;
        out_disp_len  <= rec_dl;
        out_imm_len   <= rec_il;
        out_branch    <= rec_br;
        out_target    <= rec_br ? tgt : '0;
        out_err       <= rec_err;
      end
    end
  end

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= LW'(1) && out_len <= LW'(LEN_MAX))); // R3

  AST_REC_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && !base_load)); // R2

  AST_SIDX_NEEDS_AMODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_has_sidx) |-> out_has_amode); // R5

  AST_NARROW_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_imm_len == IMM_NARROW) |-> out_has_pfx); // R7

  AST_START_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |->
      (out_start == $past(out_start) + {{PAD{1'b0}}, $past(out_len)})); // R8

  AST_BRANCH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_branch) |-> (out_len == LW'(2) + LW'(out_has_pfx))); // R9

  AST_ERR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |->
      (!out_has_amode && out_imm_len == 3'd0 && out_len == LW'(1) + LW'(out_has_pfx))); // R10
endmodule

// File: tb/vlen_boundary_dec_bench.sv
module vlen_boundary_dec_bench;
  localparam int AW = 32;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          base_load = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_byte = '0;
  logic          out_valid;
  logic [AW-1:0] out_start;
  logic [LW-1:0] out_len;
  logic [7:0]    out_opcode;
  logic          out_has_pfx, out_has_amode, out_has_sidx;
  logic [2:0]    out_disp_len, out_imm_len;
  logic          out_branch;
  logic [AW-1:0] out_target;
  logic          out_err;

  always #5 clk = ~clk;

  vlen_boundary_dec #(.AW(AW), .LW(LW)) u_vlen_boundary_dec (
    .clk(clk), .rst_n(rst_n), .base_load(base_load), .base_addr(base_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_start(out_start), .out_len(out_len),
    .out_opcode(out_opcode), .out_has_pfx(out_has_pfx),
    .out_has_amode(out_has_amode), .out_has_sidx(out_has_sidx),
    .out_disp_len(out_disp_len), .out_imm_len(out_imm_len),
    .out_branch(out_branch), .out_target(out_target), .out_err(out_err)
  );

  typedef struct {
    logic [31:0] start;
    int          len;
    logic [7:0]  opc;
    int          pfx, am, sx, dl, il, br, err;
    logic [31:0] tgt;
  } exp_t;

  exp_t        exp_q[$];
  exp_t        mon_e;
  logic [7:0]  stream_q[$];
  logic [31:0] exp_pc = '0;
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_known(input logic [7:0] b);
    return b == 8'h3B || b == 8'hBB || b == 8'hC3 || b == 8'hC7 ||
           b == 8'hF7 || b == 8'h73 || b == 8'hEB || b == 8'h66;
  endfunction

  // kind: 0 C3, 1 BB, 2 73, 3 EB, 4 3B, 5 F7, 6 C7, 7 stray opcode, 8 double prefix
  // am doubles as the offset byte for kinds 2 and 3
  task automatic make_instr(input int kind, input bit pfx, input logic [7:0] am);
    exp_t e;
    logic [7:0] opc;
    int n0, mode, rm;
    e = '{default: '0};
    n0 = stream_q.size();
    e.start = exp_pc;
    e.pfx = pfx;
    if (pfx) stream_q.push_back(8'h66);
    case (kind)
      0: opc = 8'hC3;
      1: begin opc = 8'hBB; e.il = pfx ? 2 : 4; end
      2: begin opc = 8'h73; e.br = 1; end
      3: begin opc = 8'hEB; e.br = 1; end
      4: begin opc = 8'h3B; e.am = 1; end
      5: begin opc = 8'hF7; e.am = 1; end
      6: begin opc = 8'hC7; e.am = 1; e.il = pfx ? 2 : 4; end
      7: begin
        do opc = 8'($urandom); while (is_known(opc));
        e.err = 1;
      end
      default: begin opc = 8'h66; e.err = 1; end
    endcase
    e.opc = opc;
    stream_q.push_back(opc);
    if (e.am != 0) begin
      stream_q.push_back(am);
      mode = int'(am[7:6]);
      rm = int'(am[2:0]);
      e.sx = (mode != 3 && rm == 4) ? 1 : 0;
      if (e.sx != 0) stream_q.push_back(8'($urandom));
      e.dl = (mode == 1) ? 1 : (mode == 2) ? 4 : (mode == 0 && rm == 5) ? 4 : 0;
      for (int i = 0; i < e.dl; i++) stream_q.push_back(8'($urandom));
    end
    for (int i = 0; i < e.il; i++) stream_q.push_back(8'($urandom));
    if (e.br != 0) stream_q.push_back(am);
    e.len = stream_q.size() - n0;
    if (e.br != 0) e.tgt = exp_pc + 32'(e.len) + {{24{am[7]}}, am};
    exp_q.push_back(e);
    exp_pc = exp_pc + 32'(e.len);
  endtask

  task automatic send_all();
    while (stream_q.size() != 0) begin
      if ($urandom % 4 == 0) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_valid = 1'b1;
      in_byte = stream_q.pop_front();
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    repeat (3) @(posedge clk);
    #1;
    chk("R2", "pending records", 32'(exp_q.size()), 32'd0);
  endtask

  task automatic load_base(input logic [31:0] a);
    base_load = 1'b1;
    base_addr = a;
    in_valid = 1'b1;
    in_byte = 8'hC3;
    #3;
    chk("R1", "in_ready during load", 32'(in_ready), 32'd0);
    @(posedge clk); #1;
    base_load = 1'b0;
    in_valid = 1'b0;
    #3;
    chk("R1", "in_ready after load", 32'(in_ready), 32'd1);
    exp_pc = a;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R2 unexpected record act=1 exp=0");
      end else begin
        mon_e = exp_q.pop_front();
        chk("R8", "start", out_start, mon_e.start);
        chk("R3", "len", 32'(out_len), 32'(mon_e.len));
        chk("R11", "opcode", 32'(out_opcode), 32'(mon_e.opc));
        chk("R7", "prefix", 32'(out_has_pfx), 32'(mon_e.pfx));
        chk("R11", "amode", 32'(out_has_amode), 32'(mon_e.am));
        chk("R5", "sidx", 32'(out_has_sidx), 32'(mon_e.sx));
        chk("R4", "disp_len", 32'(out_disp_len), 32'(mon_e.dl));
        chk("R6", "imm_len", 32'(out_imm_len), 32'(mon_e.il));
        chk("R9", "branch", 32'(out_branch), 32'(mon_e.br));
        chk("R9", "target", out_target, mon_e.tgt);
        chk("R10", "err", 32'(out_err), 32'(mon_e.err));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog act=timeout exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2003));
    repeat (3) @(posedge clk);
    #1;
    chk("R2", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R2", "out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1", "in_ready idle", 32'(in_ready), 32'd1);

    // R1 R8: a loop-like sequence from a loaded base
    load_base(32'h0000_01F4);
    make_instr(5, 1'b0, 8'hE3);
    make_instr(1, 1'b0, 8'h00);
    make_instr(4, 1'b0, 8'hD8);
    make_instr(2, 1'b0, 8'h0C);
    make_instr(6, 1'b0, 8'h04);
    make_instr(3, 1'b0, 8'hF0);
    make_instr(0, 1'b0, 8'h00);
    send_all();
    drain();

    // R4 R5: addressing byte shapes, F7 reg field has no length effect
    make_instr(4, 1'b0, 8'h05);
    make_instr(4, 1'b0, 8'h00);
    make_instr(4, 1'b0, 8'h44);
    make_instr(4, 1'b0, 8'h80);
    make_instr(4, 1'b0, 8'h84);
    make_instr(4, 1'b0, 8'h04);
    make_instr(4, 1'b0, 8'hC4);
    make_instr(5, 1'b0, 8'hF8);
    make_instr(5, 1'b0, 8'hC0);
    // R6 R7: immediates with and without the prefix
    make_instr(6, 1'b0, 8'h85);
    make_instr(6, 1'b1, 8'h45);
    make_instr(1, 1'b1, 8'h00);
    make_instr(0, 1'b1, 8'h00);
    make_instr(3, 1'b1, 8'h7F);
    make_instr(2, 1'b0, 8'h80);
    // R10: stray opcode and double prefix
    make_instr(7, 1'b0, 8'h00);
    make_instr(8, 1'b1, 8'h00);
    make_instr(7, 1'b1, 8'h00);
    make_instr(0, 1'b0, 8'h00);
    send_all();
    drain();

    // R9: target wraps below address zero
    load_base(32'h0000_0000);
    make_instr(3, 1'b0, 8'hF0);
    send_all();
    drain();

    // R1: a load in the middle of an instruction discards it
    stream_q.push_back(8'h3B);
    stream_q.push_back(8'h84);
    send_all();
    load_base(32'h8000_0000);
    make_instr(0, 1'b0, 8'h00);
    send_all();
    drain();

    // random mix
    for (int k = 0; k < 400; k++) begin
      int kind;
      bit pfx;
      logic [7:0] am;
      kind = int'($urandom % 9);
      pfx = ($urandom % 4 == 0) || kind == 8;
      am = 8'($urandom);
      if ($urandom % 3 == 0) am[2:0] = ($urandom % 2 == 0) ? 3'd4 : 3'd5;
      make_instr(kind, pfx, am);
      if (k % 50 == 49) send_all();
    end
    send_all();
    drain();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule